// File: doc/BRIEF.md
# DRAM Access Strobe Sequencer

This block times a normal read or write access to an asynchronous DRAM array behind a 16-bit processor bus. It runs on a clock at twice the system rate. The active-low chip select from the address decoder feeds one shift register. Fixed taps of that register give, in order, the row strobe, the row/column address select and the two byte-lane column strobes. A later tap gives the bus acknowledge. A build option takes the acknowledge from the address-select tap instead, which removes the wait states.

The 20-bit word address is split onto a 10-bit DRAM address bus. The upper half is the row and the lower half is the column, and the select tap chooses between them. The upper and lower data strobes gate the column strobe of their own byte lane. A refresh-hold input hands the row strobe to a source supplied by the refresh logic. While it is high, no normal access can start or continue.

Top module: `dram_strobe_seq`

## Requirements
- R1: While `rst` is high, and at the first sample after it, `ras_n`, `casu_n`, `casl_n` and `ack_n` are 1 and `mux_col` is 0, even with `sel_n` low.
- R2: `sel_n` may be sampled low at a rising edge while `rfsh_hold` is 0. With the default taps, `ras_n` then falls after that edge, `mux_col` rises after the 2nd edge and the column tap becomes active after the 3rd edge. No strobe changes before the first edge.
- R3: `dram_addr` equals `addr[19:10]` while `mux_col` is 0 (row phase) and `addr[9:0]` while `mux_col` is 1 (column phase).
- R4: `casu_n` is low only while the column tap is active and `uds_n` is low. `casl_n` likewise needs `lds_n` low. A lane strobe follows its data strobe with no clock delay.
- R5: At the first edge that samples `sel_n` high, the shift register clears. After that edge, `ras_n`, `casu_n`, `casl_n` and `ack_n` are 1 and `mux_col` is 0.
- R6: While `rfsh_hold` is 1, `ras_n` equals `rfsh_ras_n`, both column strobes and `ack_n` are 1 at once, and after the next edge `mux_col` is 0. A low `sel_n` starts no access until the hold drops.
- R7: With `FAST_ACK` = 0, `ack_n` falls after the 4th edge of an access. With `FAST_ACK` = 1, it falls together with the rise of `mux_col`, after the 2nd edge.
- R8: While `sel_n` stays low and hold stays 0, every asserted strobe and the acknowledge stay asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the system rate |
| rst | input | 1 | Synchronous reset, active high |
| sel_n | input | 1 | Decoded DRAM chip select, active low |
| uds_n | input | 1 | Upper byte data strobe, active low |
| lds_n | input | 1 | Lower byte data strobe, active low |
| addr | input | 20 | Word address from the processor |
| rfsh_hold | input | 1 | Refresh owns the array, active high |
| rfsh_ras_n | input | 1 | Row strobe from the refresh logic, active low |
| dram_addr | output | 10 | Multiplexed row/column address |
| ras_n | output | 1 | Row strobe, active low |
| casu_n | output | 1 | Upper lane column strobe, active low |
| casl_n | output | 1 | Lower lane column strobe, active low |
| mux_col | output | 1 | Address select, 1 for column phase |
| ack_n | output | 1 | Bus acknowledge, active low |

## Verification
The bench walks accesses with every data-strobe pattern and checks each strobe on every edge. A tap that is off by one shows up as a strobe one cycle early or late. If the address select switches before the row strobe falls, the array latches a column value as the row. A refresh hold that is raised in the middle of an access must release the column strobes and the acknowledge at once, or a normal cycle would overlap the refresh. A data strobe that rises during the column phase must lift its lane strobe in the same cycle, or the other byte gets written.

// File: rtl/dss_pkg.sv
package dss_pkg;

    // Address bus phase driven to the DRAM
    typedef enum logic {
        PH_ROW = 1'b0,
        PH_COL = 1'b1
    } addr_phase_e;

    // Active-high view of the sequencer taps
    typedef struct packed {
        logic ras;
        logic mux;
        logic cas;
        logic ack;
    } tap_t;

    function automatic logic lane_on(input logic tap_cas, input logic strobe_n,
                                     input logic hold);
        return tap_cas & ~strobe_n & ~hold;
    endfunction

endpackage

// File: rtl/dss_shift.sv
module dss_shift #(
    parameter int SR_LEN = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic [SR_LEN-1:0] stage
);

    // First stage is loaded with the access request; the others are
    // delayed copies that collapse together as soon as the request drops.
    always_ff @(posedge clk) begin
        if (rst) stage[0] <= 1'b0;
        else     stage[0] <= start;
    end

    for (genvar i = 1; i < SR_LEN; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage[i] <= 1'b0;
            else     stage[i] <= start & stage[i-1];
        end
    end

endmodule

// File: rtl/dss_tap_pick.sv
module dss_tap_pick
    import dss_pkg::*;
#(
    parameter int SR_LEN   = 4,
    parameter int TAP_RAS  = 0,
    parameter int TAP_MUX  = 1,
    parameter int TAP_CAS  = 2,
    parameter int TAP_ACK  = 3,
    parameter bit FAST_ACK = 1'b0
) (
    input  logic [SR_LEN-1:0] stage,
    output tap_t              taps
);

    assign taps.ras = stage[TAP_RAS];
    assign taps.mux = stage[TAP_MUX];
    assign taps.cas = stage[TAP_CAS];

    if (FAST_ACK) begin : g_fast_ack
        assign taps.ack = stage[TAP_MUX];
    end else begin : g_late_ack
        assign taps.ack = stage[TAP_ACK];
    end

endmodule

// File: rtl/dss_addr_mux.sv
module dss_addr_mux
    import dss_pkg::*;
#(
    parameter int DA_W = 10,
    localparam int AW  = 2 * DA_W
) (
    input  logic [AW-1:0]   addr,
    input  addr_phase_e     phase,
    output logic [DA_W-1:0] dram_addr
);

    logic [DA_W-1:0] row_part;
    logic [DA_W-1:0] col_part;

    assign row_part = addr[AW-1:DA_W];
    assign col_part = addr[DA_W-1:0];

    always_comb begin
        unique case (phase)
            PH_COL:  dram_addr = col_part;
            default: dram_addr = row_part;
        endcase
    end

endmodule

// File: rtl/dss_strobe_drv.sv
module dss_strobe_drv
    import dss_pkg::*;
(
    input  tap_t        taps,
    input  logic        uds_n,
    input  logic        lds_n,
    input  logic        rfsh_hold,
    input  logic        rfsh_ras_n,
    output addr_phase_e phase,
    output logic        mux_col,
    output logic        ras_n,
    output logic        casu_n,
    output logic        casl_n,
    output logic        ack_n
);

    assign phase   = taps.mux ? PH_COL : PH_ROW;
    assign mux_col = taps.mux;

    // Refresh owns the row strobe while it holds the array
    assign ras_n  = rfsh_hold ? rfsh_ras_n : ~taps.ras;
    assign casu_n = ~lane_on(taps.cas, uds_n, rfsh_hold);
    assign casl_n = ~lane_on(taps.cas, lds_n, rfsh_hold);
    assign ack_n  = ~(taps.ack & ~rfsh_hold);

endmodule

// File: rtl/dram_strobe_seq.sv
module dram_strobe_seq
    import dss_pkg::*;
#(
    parameter int DA_W     = 10,
    parameter int TAP_RAS  = 0,
    parameter int TAP_MUX  = 1,
    parameter int TAP_CAS  = 2,
    parameter int TAP_ACK  = 3,
    parameter bit FAST_ACK = 1'b0,
    localparam int AW      = 2 * DA_W,
    localparam int SR_LEN  = TAP_ACK + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sel_n,
    input  logic            uds_n,
    input  logic            lds_n,
    input  logic [AW-1:0]   addr,
    input  logic            rfsh_hold,
    input  logic            rfsh_ras_n,
    output logic [DA_W-1:0] dram_addr,
    output logic            ras_n,
    output logic            casu_n,
    output logic            casl_n,
    output logic            mux_col,
    output logic            ack_n
);

    logic              start;
    logic [SR_LEN-1:0] stage;
    tap_t              taps;
    addr_phase_e       phase;

    assign start = ~sel_n & ~rfsh_hold;

    dss_shift #(.SR_LEN(SR_LEN)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .stage (stage)
    );

    dss_tap_pick #(
        .SR_LEN   (SR_LEN),
        .TAP_RAS  (TAP_RAS),
        .TAP_MUX  (TAP_MUX),
        .TAP_CAS  (TAP_CAS),
        .TAP_ACK  (TAP_ACK),
        .FAST_ACK (FAST_ACK)
    ) u_taps (
        .stage (stage),
        .taps  (taps)
    );

    dss_strobe_drv u_drv (
        .taps       (taps),
        .uds_n      (uds_n),
        .lds_n      (lds_n),
        .rfsh_hold  (rfsh_hold),
        .rfsh_ras_n (rfsh_ras_n),
        .phase      (phase),
        .mux_col    (mux_col),
        .ras_n      (ras_n),
        .casu_n     (casu_n),
        .casl_n     (casl_n),
        .ack_n      (ack_n)
    );

    dss_addr_mux #(.DA_W(DA_W)) u_amux (
        .addr      (addr),
        .phase     (phase),
        .dram_addr (dram_addr)
    );

    // R2: the address switches to column only after the row strobe was low
    p_mux_after_ras_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(mux_col) |-> $past(!ras_n));

    // R2: a column strobe falls only once the column address was already out
    p_cas_after_mux_r2: assert property (@(posedge clk) disable iff (rst)
        ($fell(casu_n) || $fell(casl_n)) |-> $past(mux_col));

    // R4: a lane strobe needs its data strobe and the column phase
    p_lane_gate_r4: assert property (@(posedge clk) disable iff (rst)
        ((!casu_n |-> (!uds_n && mux_col)) and (!casl_n |-> (!lds_n && mux_col))));

    // R5: a negated select releases everything at the next edge
    p_release_r5: assert property (@(posedge clk) disable iff (rst)
        sel_n |=> (!mux_col && ack_n && casu_n && casl_n && ras_n == $past(ras_n) || !mux_col && ack_n && casu_n && casl_n && rfsh_hold || !mux_col && ack_n && casu_n && casl_n && ras_n));

    // R6: refresh hold drops the address back to the row phase
    p_hold_row_r6: assert property (@(posedge clk) disable iff (rst)
        rfsh_hold |=> !mux_col);

    // R7: acknowledge only once the column address is on the bus
    p_ack_late_r7: assert property (@(posedge clk) disable iff (rst)
        !ack_n |-> mux_col);

endmodule

// File: tb/sim_dram_strobe_seq.sv
`timescale 1ns/1ps
module sim_dram_strobe_seq;

    logic       clk = 1'b0;
    logic       rst;
    logic       sel_n, uds_n, lds_n, rfsh_hold, rfsh_ras_n;
    logic [19:0] addr;
    logic [9:0] dram_addr, dram_addr1;
    logic       ras_n, casu_n, casl_n, mux_col, ack_n;
    logic       ras1_n, casu1_n, casl1_n, mux1_col, ack1_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    dram_strobe_seq u0 (
        .clk(clk), .rst(rst), .sel_n(sel_n), .uds_n(uds_n), .lds_n(lds_n),
        .addr(addr), .rfsh_hold(rfsh_hold), .rfsh_ras_n(rfsh_ras_n),
        .dram_addr(dram_addr), .ras_n(ras_n), .casu_n(casu_n), .casl_n(casl_n),
        .mux_col(mux_col), .ack_n(ack_n)
    );

    dram_strobe_seq #(.FAST_ACK(1'b1)) u1 (
        .clk(clk), .rst(rst), .sel_n(sel_n), .uds_n(uds_n), .lds_n(lds_n),
        .addr(addr), .rfsh_hold(rfsh_hold), .rfsh_ras_n(rfsh_ras_n),
        .dram_addr(dram_addr1), .ras_n(ras1_n), .casu_n(casu1_n), .casl_n(casl1_n),
        .mux_col(mux1_col), .ack_n(ack1_n)
    );

    // {address, uds_n, lds_n}
    localparam logic [21:0] VECS [6] = '{
        {20'hABCDE, 2'b00},
        {20'h12345, 2'b01},
        {20'hFEDCB, 2'b10},
        {20'h00000, 2'b11},
        {20'hFFFFF, 2'b00},
        {20'h5A3C9, 2'b01}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    // Drive after the edge, sample mid-cycle
    task automatic to_drive();
        @(posedge clk); #2;
    endtask

    task automatic do_access(input logic [19:0] a, input logic u, input logic l);
        to_drive();
        sel_n = 1'b0; addr = a; uds_n = u; lds_n = l;
        #3;
        check("R2 ras before first edge", ras_n, 1'b1);
        check("R3 row addr", dram_addr, a[19:10]);
        for (int e = 1; e <= 6; e++) begin
            @(posedge clk); #5;
            check("R2 ras_n", ras_n, 1'b0);
            check("R2 mux_col", mux_col, e >= 2);
            check("R3 dram_addr", dram_addr, (e >= 2) ? a[9:0] : a[19:10]);
            check("R4 casu_n", casu_n, !((e >= 3) && !u));
            check("R4 casl_n", casl_n, !((e >= 3) && !l));
            check("R7 ack_n", ack_n, !(e >= 4));
            check("R7 fast ack_n", ack1_n, !(e >= 2));
            if (e >= 5) check("R8 held", {ras_n, mux_col, ack_n}, 3'b010);
        end
        sel_n = 1'b1;
        @(posedge clk); #5;
        check("R5 ras_n", ras_n, 1'b1);
        check("R5 mux_col", mux_col, 1'b0);
        check("R5 cas", {casu_n, casl_n}, 2'b11);
        check("R5 ack_n", ack_n, 1'b1);
        check("R5 row addr back", dram_addr, a[19:10]);
    endtask

    initial begin
        rst = 1'b1; sel_n = 1'b0; uds_n = 1'b0; lds_n = 1'b0; addr = 20'h0;
        rfsh_hold = 1'b0; rfsh_ras_n = 1'b1;
        repeat (3) @(posedge clk);
        #5;
        check("R1 reset strobes", {ras_n, casu_n, casl_n, ack_n}, 4'hF);
        check("R1 reset mux", mux_col, 1'b0);
        sel_n = 1'b1;
        to_drive(); rst = 1'b0;
        @(posedge clk); #5;
        check("R1 after reset", {ras_n, casu_n, casl_n, ack_n, mux_col}, 5'b11110);

        // Table of accesses
        for (int i = 0; i < 6; i++)
            do_access(VECS[i][21:2], VECS[i][1], VECS[i][0]);

        // R6: hold while idle, select low is ignored, ras follows refresh source
        to_drive();
        rfsh_hold = 1'b1; sel_n = 1'b0; addr = 20'h3FC01; uds_n = 1'b0; lds_n = 1'b0;
        for (int k = 0; k < 5; k++) begin
            rfsh_ras_n = k[0];
            #3;
            check("R6 ras follows refresh", ras_n, k[0]);
            check("R6 no access", {mux_col, casu_n, casl_n, ack_n}, 4'b0111);
            to_drive();
        end
        // Hold drops: a fresh access starts after one edge
        rfsh_hold = 1'b0; rfsh_ras_n = 1'b1;
        @(posedge clk); #5;
        check("R6 access after hold", {ras_n, mux_col}, 2'b00);
        @(posedge clk); #5;
        check("R6 mux after hold", mux_col, 1'b1);
        @(posedge clk); #5;
        check("R4 both lanes", {casu_n, casl_n}, 2'b00);

        // R4: upper data strobe rises mid column phase
        #1; uds_n = 1'b1; #1;
        check("R4 upper lane follows uds", {casu_n, casl_n}, 2'b10);
        #1; uds_n = 1'b0;

        // R6: hold raised mid-access releases at once
        @(posedge clk); #2;
        rfsh_hold = 1'b1; rfsh_ras_n = 1'b1; #3;
        check("R6 cas released", {casu_n, casl_n}, 2'b11);
        check("R6 ack released", ack_n, 1'b1);
        check("R6 ras from refresh", ras_n, 1'b1);
        @(posedge clk); #5;
        check("R6 mux row", mux_col, 1'b0);
        check("R3 row addr under hold", dram_addr, 10'h0FF);
        rfsh_hold = 1'b0; sel_n = 1'b1;
        @(posedge clk); #5;
        check("R5 idle", {ras_n, casu_n, casl_n, ack_n}, 4'hF);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog act=hung exp=done");
            summary();
            $finish;
        end
    end

endmodule